// File: doc/BRIEF.md
# DMA Channel Interrupt Register Set

This block holds the interrupt state of one DMA channel. The transfer engine reports events as single-cycle pulses on an eight-bit vector. Each pulse sets a sticky status bit, which stays set until software clears it by writing a one to it. Software controls which sources may raise the interrupt line. It does this only through two write-only registers: one unmasks sources and the other masks them. The resulting mask can be read back but cannot be written directly.

Every completion pulse also advances a three-bit completion counter. The counter wraps at eight. It is read in the engine status word together with the busy flag, the FIFO level and the outstanding-command count, all three of which come from the engine. When software acknowledges a completion by clearing the set DONE bit, the counter steps back by one. Software can therefore tell how many completions are still unacknowledged.

All access is through a 32-bit register port with byte offsets. Reads return data one cycle after the request. The interrupt output is a registered level.

Top module: `dma_irq_regs`

## Requirements
- R1: While reset is held and in the first cycle after it, the following values hold: the interrupt status is 0, the mask is 0xFF, the completion counter is 0, irq_o is low and rdata_o is 0.
- R2: An event pulse sets the matching status bit, and the bit stays set while no clearing write arrives. The status bits are: 7 FIFO overflow, 6 invalid bus access, 5 threshold hit, 4 memory timeout, 3 stream timeout, 2 bus write-response error, 1 DONE, 0 MEM_DONE. Status reads at offset 0x14 in bits [7:0].
- R3: A write to 0x14 clears every status bit written as 1. Bits written as 0 keep their value.
- R4: If an event and a clearing write hit the same status bit in one cycle, the bit stays set.
- R5: Writing 1s to 0x18 clears the matching mask bits, and writing 1s to 0x1C sets them. Zero bits have no effect. The mask reads at 0x20, and 0x18 and 0x1C read as 0.
- R6: irq_o is high exactly when some status bit is set whose mask bit is clear. It changes in the same cycle as the register state it reflects.
- R7: Each DONE event (bit 1) increments the completion counter, which reads at 0x08 bits [15:13] and wraps modulo 8.
- R8: A write of 1 to status bit 1 decrements the counter only while DONE is set. A DONE event in that same cycle cancels the decrement.
- R9: Offset 0x08 reads the busy input in bit 0, the outstanding count in [4:1] and the FIFO level in [12:5]. Writes to 0x08 change nothing.
- R10: rdata_o is updated one clock after rd_en_i with the values held before any write in that cycle. It holds its value otherwise, and unmapped offsets read 0.
- R11: Writes to the mask offset 0x20 leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event pulses from the transfer engine, one per status bit |
| busy_i | input | 1 | Engine busy flag, shown in the status word |
| fifo_lvl_i | input | 8 | Engine FIFO level, shown in the status word |
| outs_i | input | 4 | Outstanding command count, shown in the status word |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench aims at the cycle where an event and a clearing write land on the same bit. A design that gave the write priority would lose an interrupt, and a design that decremented the counter anyway would drift from the true completion count. It drives ten completions to make the counter wrap, and it clears DONE while DONE is already clear. A counter that saturates, or that decrements on every write, would show the wrong value at bits [15:13]. It also writes to the read-only mask and engine-status offsets, and it checks that masked sources keep irq_o low while their status still reads back set.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned NSRC = 8;
  localparam int unsigned BIT_DONE = 1;

  localparam logic [7:0] OFS_ENG  = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_EN   = 8'h18;
  localparam logic [7:0] OFS_DIS  = 8'h1C;
  localparam logic [7:0] OFS_MASK = 8'h20;
endpackage

// File: rtl/irq_sticky_status.sv
module irq_sticky_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] st_o,
  output logic [N-1:0] st_next_o
);
  logic [N-1:0] st_q;

  // an event in the same cycle as a clear keeps the bit set
  assign st_next_o = (st_q & ~clr_i) | evt_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) st_q <= '0;
    else       st_q <= st_next_o;
  end

  assign st_o = st_q;

  // R4
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (evt_i != '0) |=> ((st_q & $past(evt_i)) == $past(evt_i)));

  // R3
  clr_works_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((clr_i & ~evt_i) != '0) |=> ((st_q & $past(clr_i & ~evt_i)) == '0));

  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i == '0) |=> ((st_q & $past(st_q)) == $past(st_q)));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] dis_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] mask_next_o
);
  logic [N-1:0] mask_q;

  assign mask_next_o = (mask_q & ~en_i) | dis_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) mask_q <= '1;
    else       mask_q <= mask_next_o;
  end

  assign mask_o = mask_q;

  // R5
  unmask_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((en_i != '0) && (dis_i == '0)) |=> ((mask_q & $past(en_i)) == '0));

  // R5
  mask_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (dis_i != '0) |=> ((mask_q & $past(dis_i)) == $past(dis_i)));
endmodule

// File: rtl/done_counter.sv
module done_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                 cnt_q <= '0;
    else if (inc_i && !dec_i)  cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  // R7
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (inc_i && !dec_i) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  // R8
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (dec_i && !inc_i) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

  // R8
  cnt_cancel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (inc_i == dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned FIFO_W = 8,
  parameter int unsigned OUTS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              busy_i,
  input  logic [FIFO_W-1:0] fifo_lvl_i,
  input  logic [OUTS_W-1:0] outs_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned OUTS_LSB = 1;
  localparam int unsigned FIFO_LSB = OUTS_LSB + OUTS_W;
  localparam int unsigned CNT_LSB  = FIFO_LSB + FIFO_W;
  localparam int unsigned ENG_W    = CNT_LSB + CNT_W;

  localparam logic [ADDR_W-1:0] A_ENG  = ADDR_W'(OFS_ENG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  logic [NSRC-1:0]   clr, en, dis;
  logic [NSRC-1:0]   st, st_next, mask, mask_next;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_dec, cnt_inc;
  logic [ENG_W-1:0]  eng_word;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  assign clr = (wr_en_i && addr_i == A_STAT) ? wdata_i[NSRC-1:0] : '0;
  assign en  = (wr_en_i && addr_i == A_EN)   ? wdata_i[NSRC-1:0] : '0;
  assign dis = (wr_en_i && addr_i == A_DIS)  ? wdata_i[NSRC-1:0] : '0;

  assign cnt_inc = evt_i[BIT_DONE];
  assign cnt_dec = clr[BIT_DONE] & st[BIT_DONE];

  irq_sticky_status #(.N(NSRC)) u_status (
    .clk_i(clk_i), .rst_i(rst_i), .evt_i(evt_i), .clr_i(clr),
    .st_o(st), .st_next_o(st_next)
  );

  irq_mask_bank #(.N(NSRC)) u_mask (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en), .dis_i(dis),
    .mask_o(mask), .mask_next_o(mask_next)
  );

  done_counter #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .inc_i(cnt_inc), .dec_i(cnt_dec),
    .cnt_o(cnt)
  );

  assign eng_word = {cnt, fifo_lvl_i, outs_i, busy_i};

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_ENG:   rd_mux = DATA_W'(eng_word);
      A_STAT:  rd_mux = DATA_W'(st);
      A_MASK:  rd_mux = DATA_W'(mask);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= rd_mux;
      irq_q <= |(st_next & ~mask_next);
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    rst_i |=> (st == '0 && mask == '1 && cnt == '0 && !irq_o && rdata_o == '0));

  // R6
  irq_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o == |(st & ~mask));

  // R11
  mask_ro_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == A_MASK) |=> $stable(mask));

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_dma_irq_regs.sv
`timescale 1ns/1ps
module tb_dma_irq_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt = '0;
  logic        busy = 1'b0;
  logic [7:0]  fifo = '0;
  logic [3:0]  outs = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  dma_irq_regs dut (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .busy_i(busy),
    .fifo_lvl_i(fifo), .outs_i(outs), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  int m_st, m_mk, m_cnt, m_irq, m_clr, m_en, m_dis, m_inc, m_dec;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_mk = 255; m_cnt = 0; m_irq = 0; m_rd = 0;
    end else begin
      if (rd_en) begin
        if (addr == 8'h08)      m_rd = (m_cnt << 13) | (int'(fifo) << 5) | (int'(outs) << 1) | int'(busy);
        else if (addr == 8'h14) m_rd = m_st;
        else if (addr == 8'h20) m_rd = m_mk;
        else                    m_rd = 0;
      end
      m_clr = (wr_en && addr == 8'h14) ? int'(wdata[7:0]) : 0;
      m_en  = (wr_en && addr == 8'h18) ? int'(wdata[7:0]) : 0;
      m_dis = (wr_en && addr == 8'h1C) ? int'(wdata[7:0]) : 0;
      m_inc = (int'(evt) >> 1) & 1;
      m_dec = ((m_clr >> 1) & 1) & ((m_st >> 1) & 1);
      m_st  = ((m_st & ~m_clr) | int'(evt)) & 255;
      m_mk  = ((m_mk & ~m_en) | m_dis) & 255;
      m_cnt = (m_cnt + m_inc - m_dec + 8) % 8;
      m_irq = ((m_st & ~m_mk & 255) != 0) ? 1 : 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    check(irq === m_irq[0], "R6 irq vs model", {31'b0, irq}, m_irq);
    check(rdata === m_rd, "R10 rdata vs model", rdata, m_rd);
  end

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rdata === exp, tag, rdata, exp);
  endtask

  task automatic pulse(input logic [7:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(irq === 1'b0, "R1 irq after reset", {31'b0, irq}, 0);
    do_rd(8'h20, 32'hFF, "R1 mask reset");
    do_rd(8'h14, 32'h0, "R1 status reset");
    do_rd(8'h08, 32'h0, "R1 counter reset");

    pulse(8'h84);
    check(irq === 1'b0, "R6 masked sources keep irq low", {31'b0, irq}, 0);
    do_rd(8'h14, 32'h84, "R2 status sticky");
    do_rd(8'h14, 32'h84, "R2 status still set");

    do_wr(8'h18, 32'h04);
    do_rd(8'h20, 32'hFB, "R5 enable clears mask bit");
    check(irq === 1'b1, "R6 unmasked source raises irq", {31'b0, irq}, 1);
    do_rd(8'h18, 32'h0, "R5 enable reads zero");
    do_rd(8'h1C, 32'h0, "R5 disable reads zero");

    do_wr(8'h14, 32'h80);
    do_rd(8'h14, 32'h04, "R3 write-one clears only that bit");
    check(irq === 1'b1, "R6 irq still high", {31'b0, irq}, 1);
    do_wr(8'h14, 32'h04);
    check(irq === 1'b0, "R6 irq drops after clear", {31'b0, irq}, 0);

    do_wr(8'h1C, 32'h04);
    do_rd(8'h20, 32'hFF, "R5 disable sets mask bit");
    do_wr(8'h20, 32'h00);
    do_rd(8'h20, 32'hFF, "R11 mask write ignored");

    for (int i = 0; i < 10; i++) pulse(8'h03);
    do_rd(8'h08, 32'h4000, "R7 counter wraps to 2");
    do_wr(8'h14, 32'h02);
    do_rd(8'h08, 32'h2000, "R8 clearing DONE decrements");
    do_rd(8'h14, 32'h01, "R3 DONE cleared, MEM_DONE kept");
    do_wr(8'h14, 32'h02);
    do_rd(8'h08, 32'h2000, "R8 no decrement when DONE clear");

    evt = 8'h02; wr_en = 1'b1; addr = 8'h14; wdata = 32'h02;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    do_rd(8'h14, 32'h03, "R4 event wins over clear");
    do_rd(8'h08, 32'h4000, "R8 increment with DONE clear");
    evt = 8'h02; wr_en = 1'b1; addr = 8'h14; wdata = 32'h02;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    do_rd(8'h08, 32'h4000, "R8 event cancels decrement");
    do_rd(8'h14, 32'h03, "R4 DONE stays set");

    busy = 1'b1; fifo = 8'hA5; outs = 4'h9;
    do_rd(8'h08, 32'h4000 | (32'hA5 << 5) | (32'h9 << 1) | 32'h1, "R9 engine fields");
    do_wr(8'h08, 32'hFFFFFFFF);
    do_rd(8'h08, 32'h4000 | (32'hA5 << 5) | (32'h9 << 1) | 32'h1, "R9 writes ignored");
    held = rdata;
    repeat (2) @(negedge clk);
    check(rdata === held, "R10 rdata holds", rdata, held);
    do_rd(8'h04, 32'h0, "R10 unmapped reads zero");

    for (int i = 0; i < 400; i++) begin
      evt   = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h0;
      busy  = 1'($urandom);
      fifo  = 8'($urandom);
      outs  = 4'($urandom);
      case ($urandom_range(0, 5))
        0: addr = 8'h08;
        1: addr = 8'h14;
        2: addr = 8'h18;
        3: addr = 8'h1C;
        4: addr = 8'h20;
        default: addr = 8'h0C;
      endcase
      wr_en = 1'($urandom);
      rd_en = 1'($urandom);
      wdata = $urandom;
      @(negedge clk);
    end
    evt = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule